// File: doc/BRIEF.md
# FP Sign-Injection and Raw-Move Unit

This unit handles the floating-point operations that never round: copying a
sign from one operand onto another, and moving raw bit patterns between the
integer and floating-point register files. The floating-point register file
is 64 bits wide and holds both single and double values. Single values sit in
the low 32 bits. The upper 32 bits are all ones, which is the NaN-boxed form.

Each accepted operation carries two FP operands, one integer operand, an
operation code and a format code. One cycle later the unit presents a
registered result on a one-entry output stage. The input side accepts a new
operation whenever the output stage is empty or is being drained in that same
cycle (`in_ready = !out_valid || out_ready`). When `out_ready` is low and a
result is waiting, that result and its flags stay frozen and `in_ready` is
low. A transfer on either side takes place only when valid and ready are both
high at a rising clock edge.

Top module: `fpsm_unit`

## Requirements
- R1: With op 0 (sign copy), the result is operand A with its format sign bit replaced by the sign bit of operand B.
- R2: With op 1 (inverted sign copy), the result is operand A with its format sign bit replaced by the inverse of operand B's sign bit.
- R3: With op 2 (sign xor), the result is operand A with its format sign bit XORed with operand B's sign bit.
- R4: Format 0 is single, and its sign is bit 31. Format 1 is double, and its sign is bit 63. For single sign operations only bits 31:0 of each operand are used, so the upper operand bits have no effect on the result.
- R5: Every single-format FP result (ops 0, 1, 2, 4) has bits 63:32 equal to all ones.
- R6: With op 3 (FP to integer move), `out_int` is the low format-width bits of operand A, sign-extended to 64 bits, and `out_to_int` is 1.
- R7: With op 4 (integer to FP move), `out_fp` holds the low format-width bits of the integer operand. For double these are all 64 bits. For single they are bits 31:0, boxed as in R5.
- R8: An op code of 5 to 7 or a format code of 2 or 3 produces a result beat with `out_err`=1, in which `out_fp` and `out_int` are zero.
- R9: A result beat is presented exactly one cycle after its operation is accepted. `out_to_int` is 1 only for op 3. The result bus that the op does not write is zero.
- R10: While `out_valid`=1 and `out_ready`=0, the result beat stays unchanged and `in_ready` is 0. An offered operation is taken in the cycle in which the output drains.
- R11: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | An operation is offered |
| in_ready | output | 1 | The unit can take an operation |
| in_op | input | 3 | Operation code (0..4 valid) |
| in_fmt | input | 2 | Format code (0 single, 1 double) |
| in_fa | input | 64 | FP operand A |
| in_fb | input | 64 | FP operand B |
| in_x | input | 64 | Integer operand |
| out_valid | output | 1 | A result beat is present |
| out_ready | input | 1 | The downstream side takes the beat |
| out_err | output | 1 | The op or format code was unsupported |
| out_to_int | output | 1 | The beat targets the integer file |
| out_fp | output | 64 | FP result |
| out_int | output | 64 | Integer result |

## Verification
The hardest case to reach is an operand whose upper bits contradict its format. An example is a single operation whose inputs are not NaN-boxed and whose bit 63 differs from bit 31. A unit that read the wrong sign bit would still look correct on tidy inputs. The sweep therefore builds operands from a mixing generator and then forces the four combinations of bit 31 and bit 63 independently. This runs across every op and format code, including the unsupported ones. A separate stall sequence holds `out_ready` low while a second operation waits. This checks that the frozen beat survives and that the waiting operation lands on the drain cycle.

// File: rtl/fpsm_pkg.sv
package fpsm_pkg;
  localparam int SGL_W = 32;

  typedef enum logic [2:0] {
    OP_SCOPY = 3'd0,
    OP_SNEG  = 3'd1,
    OP_SXOR  = 3'd2,
    OP_F2X   = 3'd3,
    OP_X2F   = 3'd4
  } fpsm_op_e;

  typedef enum logic [1:0] {
    FMT_SGL = 2'd0,
    FMT_DBL = 2'd1
  } fpsm_fmt_e;

  typedef struct packed {
    logic bad;
    logic is_sign;
    logic to_int;
    logic to_fp_move;
    logic single;
    logic [1:0] smode;
  } fpsm_dec_t;
endpackage

// File: rtl/fpsm_decode.sv
module fpsm_decode
  import fpsm_pkg::*;
(
  input  logic [2:0] op,
  input  logic [1:0] fmt,
  output fpsm_dec_t  dec
);
  logic op_ok, fmt_ok;

  always_comb begin
    op_ok  = (op <= 3'd4);
    fmt_ok = (fmt == FMT_SGL) || (fmt == FMT_DBL);
    dec.bad        = !(op_ok && fmt_ok);
    dec.is_sign    = op_ok && fmt_ok && (op <= 3'd2);
    dec.to_int     = op_ok && fmt_ok && (op == OP_F2X);
    dec.to_fp_move = op_ok && fmt_ok && (op == OP_X2F);
    dec.single     = (fmt == FMT_SGL);
    dec.smode      = op[1:0];
  end
endmodule

// File: rtl/fpsm_sgn.sv
module fpsm_sgn #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [1:0]   mode,
  output logic [W-1:0] res
);
  logic ns;

  always_comb begin
    unique case (mode)
      2'd0:    ns = b[W-1];
      2'd1:    ns = ~b[W-1];
      default: ns = a[W-1] ^ b[W-1];
    endcase
    res = {ns, a[W-2:0]};
  end
endmodule

// File: rtl/fpsm_move.sv
module fpsm_move #(
  parameter int FLEN = 64,
  parameter int XLEN = 64
) (
  input  logic [FLEN-1:0] fa,
  input  logic [XLEN-1:0] x,
  input  logic            single,
  output logic [XLEN-1:0] to_int,
  output logic [FLEN-1:0] to_fp
);
  localparam int SW = fpsm_pkg::SGL_W;

  always_comb begin
    if (single) begin
      to_int = {{(XLEN-SW){fa[SW-1]}}, fa[SW-1:0]};
      to_fp  = {{(FLEN-SW){1'b1}}, x[SW-1:0]};
    end else begin
      to_int = {{(XLEN-FLEN+1){fa[FLEN-1]}}, fa[FLEN-2:0]};
      to_fp  = x[FLEN-1:0];
    end
  end
endmodule

// File: rtl/fpsm_unit.sv
module fpsm_unit
  import fpsm_pkg::*;
#(
  parameter int FLEN = 64,
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [2:0]      in_op,
  input  logic [1:0]      in_fmt,
  input  logic [FLEN-1:0] in_fa,
  input  logic [FLEN-1:0] in_fb,
  input  logic [XLEN-1:0] in_x,
  output logic            out_valid,
  input  logic            out_ready,
  output logic            out_err,
  output logic            out_to_int,
  output logic [FLEN-1:0] out_fp,
  output logic [XLEN-1:0] out_int
);
  localparam int SW    = SGL_W;
  localparam int NFMT  = 2;

  fpsm_dec_t dec;
  logic [FLEN-1:0] sgn_res [NFMT];
  logic [FLEN-1:0] mv_fp;
  logic [XLEN-1:0] mv_int;
  logic [FLEN-1:0] nxt_fp;
  logic [XLEN-1:0] nxt_int;
  logic            take;
  logic            r_single;

  fpsm_decode u_dec (.op(in_op), .fmt(in_fmt), .dec(dec));

  for (genvar g = 0; g < NFMT; g++) begin : g_fmt
    localparam int W = (g == 0) ? SW : FLEN;
    logic [W-1:0] r;
    fpsm_sgn #(.W(W)) u_sgn (
      .a(in_fa[W-1:0]), .b(in_fb[W-1:0]), .mode(dec.smode), .res(r)
    );
    if (W < FLEN) begin : g_box
      assign sgn_res[g] = {{(FLEN-W){1'b1}}, r};
    end else begin : g_full
      assign sgn_res[g] = r;
    end
  end

  fpsm_move #(.FLEN(FLEN), .XLEN(XLEN)) u_mv (
    .fa(in_fa), .x(in_x), .single(dec.single), .to_int(mv_int), .to_fp(mv_fp)
  );

  always_comb begin
    nxt_fp  = '0;
    nxt_int = '0;
    if (dec.is_sign)         nxt_fp  = dec.single ? sgn_res[0] : sgn_res[1];
    else if (dec.to_fp_move) nxt_fp  = mv_fp;
    else if (dec.to_int)     nxt_int = mv_int;
  end

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_err    <= 1'b0;
      out_to_int <= 1'b0;
      out_fp     <= '0;
      out_int    <= '0;
      r_single   <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (take) begin
        out_err    <= dec.bad;
        out_to_int <= dec.to_int;
        out_fp     <= nxt_fp;
        out_int    <= nxt_int;
        r_single   <= dec.single;
      end
    end
  end

  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid); // R9
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_fp) && $stable(out_int)
                                   && $stable(out_err) && $stable(out_to_int))); // R10
  AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_err) |-> (out_fp == '0 && out_int == '0 && !out_to_int)); // R8
  AST_SGL_BOXED: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_err && !out_to_int && r_single) |-> (&out_fp[FLEN-1:SW])); // R5
  AST_SEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_to_int && r_single) |-> (out_int[XLEN-1:SW] == {(XLEN-SW){out_int[SW-1]}})); // R6
  AST_INT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_to_int) |-> (out_int == '0)); // R9
endmodule

// File: tb/fpsm_unit_tb.sv
`timescale 1ns/1ps
module fpsm_unit_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b1;
  logic [2:0] in_op = '0;
  logic [1:0] in_fmt = '0;
  logic [63:0] in_fa = '0, in_fb = '0, in_x = '0;
  logic in_ready, out_valid, out_err, out_to_int;
  logic [63:0] out_fp, out_int;
  int n_chk = 0, n_bad = 0;
  int cyc = 0;
  logic [63:0] seed = 64'h9E3779B97F4A7C15;

  always #2.5 clk = ~clk;

  fpsm_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_fmt(in_fmt), .in_fa(in_fa), .in_fb(in_fb), .in_x(in_x),
    .out_valid(out_valid), .out_ready(out_ready), .out_err(out_err),
    .out_to_int(out_to_int), .out_fp(out_fp), .out_int(out_int)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: act=hung exp=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mix();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 7);
    seed = seed ^ (seed << 17);
    return seed;
  endfunction

  // Expected values from the requirements, written arithmetically.
  task automatic expect_of(input int op, input int fmt, input logic [63:0] a,
                           input logic [63:0] b, input logic [63:0] x,
                           output logic e_err, output logic e_ti,
                           output logic [63:0] e_fp, output logic [63:0] e_int);
    longint unsigned sbit, amag, sa, sb, ns;
    e_err = (op > 4) || (fmt > 1);
    e_ti = 0; e_fp = 0; e_int = 0;
    if (e_err) return;
    sbit = (fmt == 0) ? 64'd2147483648 : 64'h8000000000000000;
    if (op <= 2) begin
      amag = (fmt == 0) ? (a % 64'd2147483648) : (a & ~sbit);
      sa = ((a & sbit) != 0) ? 1 : 0;
      sb = ((b & sbit) != 0) ? 1 : 0;
      ns = (op == 0) ? sb : (op == 1) ? 1 - sb : (sa + sb) % 2;
      e_fp = amag + ns * sbit;
      if (fmt == 0) e_fp = e_fp + 64'hFFFFFFFF00000000;
    end else if (op == 3) begin
      e_ti = 1;
      if (fmt == 0) begin
        e_int = a % 64'd4294967296;
        if (e_int >= 64'd2147483648) e_int = e_int + 64'hFFFFFFFF00000000;
      end else e_int = a;
    end else begin
      e_fp = (fmt == 0) ? (x % 64'd4294967296) + 64'hFFFFFFFF00000000 : x;
    end
  endtask

  task automatic send(input int op, input int fmt, input logic [63:0] a,
                      input logic [63:0] b, input logic [63:0] x);
    @(negedge clk);
    in_valid = 1; in_op = op[2:0]; in_fmt = fmt[1:0];
    in_fa = a; in_fb = b; in_x = x;
    @(negedge clk);
    in_valid = 0;
  endtask

  function automatic string tag(input int op, input int fmt);
    if (op > 4 || fmt > 1) return "R8";
    case (op)
      0: return (fmt == 0) ? "R1/R4/R5" : "R1";
      1: return "R2";
      2: return "R3";
      3: return "R6";
      default: return "R7";
    endcase
  endfunction

  initial begin
    logic e_err, e_ti;
    logic [63:0] e_fp, e_int, a, b, x, held;
    #12;
    chk("R11 out_valid", {63'd0, out_valid}, 64'd0);
    chk("R11 in_ready", {63'd0, in_ready}, 64'd1);
    @(negedge clk); rst_n = 1;
    for (int op = 0; op < 8; op++)
      for (int fmt = 0; fmt < 4; fmt++)
        for (int k = 0; k < 16; k++) begin
          a = mix(); b = mix(); x = mix();
          a[31] = k[0]; a[63] = k[1]; b[31] = k[2]; b[63] = k[3];
          if (k >= 8) x[31] = ~x[31];
          send(op, fmt, a, b, x);
          expect_of(op, fmt, a, b, x, e_err, e_ti, e_fp, e_int);
          chk({tag(op, fmt), " R9 valid"}, {63'd0, out_valid}, 64'd1);
          chk({tag(op, fmt), " err"}, {63'd0, out_err}, {63'd0, e_err});
          chk({tag(op, fmt), " R9 to_int"}, {63'd0, out_to_int}, {63'd0, e_ti});
          chk({tag(op, fmt), " fp"}, out_fp, e_fp);
          chk({tag(op, fmt), " int"}, out_int, e_int);
        end
    // R9: beat lasts one cycle with no new input
    @(negedge clk);
    chk("R9 drain", {63'd0, out_valid}, 64'd0);
    // R10: back-pressure
    out_ready = 0;
    send(1, 1, 64'h0123456789ABCDEF, 64'h0, 64'h0);
    held = 64'h8123456789ABCDEF;
    chk("R10 first beat", out_fp, held);
    chk("R10 in_ready low", {63'd0, in_ready}, 64'd0);
    in_valid = 1; in_op = 3'd4; in_fmt = 2'd0; in_x = 64'h5555_5555_DEAD_BEEF;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R10 hold fp", out_fp, held);
      chk("R10 hold valid", {63'd0, out_valid}, 64'd1);
    end
    out_ready = 1;
    @(negedge clk);
    in_valid = 0;
    chk("R10 R7 queued beat", out_fp, 64'hFFFFFFFF_DEADBEEF);
    chk("R10 queued valid", {63'd0, out_valid}, 64'd1);
    @(negedge clk);
    chk("R10 drained", {63'd0, out_valid}, 64'd0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule